// File: doc/BRIEF.md
# Logic BIST Sequencing Controller

This block runs a logic self-test of the core it sits beside. A one-cycle start command launches a fixed sequence. The controller raises a busy flag, isolates the pads, and pulses a flush reset. It then loads the test count and seeds. Next it steps a pattern generator and a signature register once per test cycle until the count reaches zero. A second flush reset follows, and the busy flag drops. The system clock keeps running throughout.

Two start modes exist. In built-in mode, the count and both seeds come from parameters. In user mode, software writes them through a small register port before issuing start. No interrupt marks completion. Software polls the status word and then reads the signature. The core under test and the pad isolation are stand-in models. The core model returns one response word per test cycle. The pad model masks inputs to zero and turns the output enable off.

Top module: `lbist_ctrl`

## Requirements
- R1: `start` sampled high while idle makes `busy` high on the next cycle, and `start_user` is captured at that point as the mode. `start` sampled while `busy` is high has no effect on the run length or on the signature.
- R2: With a loaded count N, a run keeps `busy` high for exactly N+11 cycles, in this order: 1 isolation cycle, a 4-cycle flush pulse, 1 load cycle, N+1 run cycles, and a 4-cycle flush pulse. `flush_rst` is high in exactly two pulses of 4 cycles each. `io_isolate` is high whenever `busy` is high.
- R3: Built-in mode (`start_user`=0) loads count 83264, pattern seed 32'hACE1_2468 and signature seed 32'hFFFF_FFFF at the load step, replacing any written values.
- R4: User mode (`start_user`=1) runs with the count, pattern seed and signature seed last written while idle. Register addresses: 0 status, 1 count, 2 pattern generator, 3 signature.
- R5: Each run cycle advances the pattern generator P to {P[30:0], P[31]^P[21]^P[1]^P[0]}. After a run, address 2 reads the final P.
- R6: Each run cycle updates the signature S to {S[30:0], S[31]^S[21]^S[1]^S[0]} ^ R, with R = {P[15:0], P[31:16]} ^ 32'h5A5A_C3C3 taken from P before its advance. Address 3 reads S.
- R7: The count decrements once per run cycle, and the run phase ends when it reaches 0. A count of 0 gives no run steps, so the signature is unchanged. After any run, address 1 reads 0.
- R8: A status read while idle returns bit0 busy=0, bit1 done, bit2 last mode (1 = user), zeros above, and bit31 chosen so that the word has even parity. The read then clears done. Done is set when a run ends.
- R9: A status read while busy returns 32'h0000_0001 and clears nothing.
- R10: Register writes while busy are ignored.
- R11: While busy, `func_oe` is 0 and the core sees zero inputs. The flush clears the core register. When idle, `func_out` shows `func_in` one cycle later with `func_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start command |
| start_user | input | 1 | Mode qualifier for start: 1 user, 0 built-in |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after `reg_rd` |
| busy | output | 1 | Test sequence in progress |
| io_isolate | output | 1 | Pad isolation request |
| flush_rst | output | 1 | Flush reset pulse to the core |
| func_in | input | 32 | Functional input from the pads |
| func_out | output | 32 | Functional output to the pads |
| func_oe | output | 1 | Pad output enable |

## Verification
`busy` rises one cycle after `start` is sampled and stays high for N+11 cycles. The bench samples every output on falling edges and counts busy, flush and isolation cycles one by one against that total. Read data lands one cycle after the read strobe, so each read task samples at the following falling edge. The core register follows `func_in` with one cycle of latency, so it is checked at the first idle falling edge after a run (zero) and again one cycle later. Signatures and final pattern values are rebuilt in the bench from the R5 and R6 formulas and compared after `busy` has fallen.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISO, ST_FLUSH1, ST_LOAD, ST_RUN, ST_FLUSH2
  } seq_state_e;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_PRPG   = 2'd2;
  localparam logic [1:0] ADDR_SIG    = 2'd3;
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
  parameter int          W        = 32,
  parameter logic [W-1:0] TAPS    = 32'h8020_0003,
  parameter logic [W-1:0] SEED_DEF = 32'hACE1_2468
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load_def,
  input  logic         step,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= SEED_DEF;
    else if (load_def) q <= SEED_DEF;
    else if (step)     q <= {q[W-2:0], fb};
    else if (wr)       q <= wdata;
  end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int           W        = 32,
  parameter logic [W-1:0] TAPS     = 32'h8020_0003,
  parameter logic [W-1:0] SEED_DEF = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load_def,
  input  logic         step,
  input  logic [W-1:0] resp,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= SEED_DEF;
    else if (load_def) q <= SEED_DEF;
    else if (step)     q <= {q[W-2:0], fb} ^ resp;
    else if (wr)       q <= wdata;
  end
endmodule

// File: rtl/lbist_core_stub.sv
module lbist_core_stub #(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = 32'h5A5A_C3C3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         iso,
  input  logic [W-1:0] func_in,
  input  logic [W-1:0] prpg,
  output logic [W-1:0] func_out,
  output logic         func_oe,
  output logic [W-1:0] resp
);
  localparam int H = W / 2;
  logic [W-1:0] core_q;
  logic [W-1:0] core_in;

  assign core_in = iso ? '0 : func_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     core_q <= '0;
    else if (flush) core_q <= '0;
    else            core_q <= core_in;
  end

  assign func_out = core_q;
  assign func_oe  = ~iso;
  assign resp     = {prpg[H-1:0], prpg[W-1:H]} ^ MASK ^ core_q;
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int CW        = 32,
  parameter int DEF_COUNT = 83264,
  parameter int FLUSH_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_user,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  output logic          busy,
  output logic          io_iso,
  output logic          flush,
  output logic          load_def,
  output logic          run_step,
  output logic          user_mode,
  output logic          fin,
  output logic [CW-1:0] cnt_q
);
  localparam int FW = (FLUSH_LEN > 1) ? $clog2(FLUSH_LEN) : 1;
  localparam logic [FW-1:0] FLAST = FW'(FLUSH_LEN - 1);

  seq_state_e    st;
  logic [FW-1:0] fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      fcnt      <= '0;
      cnt_q     <= '0;
      user_mode <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            st        <= ST_ISO;
            user_mode <= start_user;
          end else if (cnt_wr) begin
            cnt_q <= cnt_wdata;
          end
        end
        ST_ISO: begin
          st   <= ST_FLUSH1;
          fcnt <= '0;
        end
        ST_FLUSH1: begin
          if (fcnt == FLAST) st <= ST_LOAD;
          else               fcnt <= fcnt + FW'(1);
        end
        ST_LOAD: begin
          if (!user_mode) cnt_q <= CW'(DEF_COUNT);
          st <= ST_RUN;
        end
        ST_RUN: begin
          if (cnt_q == '0) begin
            st   <= ST_FLUSH2;
            fcnt <= '0;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_FLUSH2: begin
          if (fcnt == FLAST) st <= ST_IDLE;
          else               fcnt <= fcnt + FW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign io_iso   = busy;
  assign flush    = (st == ST_FLUSH1) || (st == ST_FLUSH2);
  assign load_def = (st == ST_LOAD) && !user_mode;
  assign run_step = (st == ST_RUN) && (cnt_q != '0);
  assign fin      = (st == ST_FLUSH2) && (fcnt == FLAST);
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int           W         = 32,
  parameter int           DEF_COUNT = 83264,
  parameter int           FLUSH_LEN = 4,
  parameter logic [W-1:0] TAPS      = 32'h8020_0003,
  parameter logic [W-1:0] PRPG_DEF  = 32'hACE1_2468,
  parameter logic [W-1:0] SIG_DEF   = 32'hFFFF_FFFF,
  parameter logic [W-1:0] RESP_MASK = 32'h5A5A_C3C3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_user,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         busy,
  output logic         io_isolate,
  output logic         flush_rst,
  input  logic [W-1:0] func_in,
  output logic [W-1:0] func_out,
  output logic         func_oe
);
  logic         load_def, run_step, user_mode, fin, done_q;
  logic [W-1:0] cnt_val, prpg_q, sig_q, resp;
  logic         wr_ok;
  logic [W-1:0] status_idle;

  assign wr_ok = reg_wr && !busy;

  lbist_seq #(.CW(W), .DEF_COUNT(DEF_COUNT), .FLUSH_LEN(FLUSH_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_user(start_user),
    .cnt_wr(wr_ok && reg_addr == ADDR_COUNT), .cnt_wdata(reg_wdata),
    .busy(busy), .io_iso(io_isolate), .flush(flush_rst), .load_def(load_def),
    .run_step(run_step), .user_mode(user_mode), .fin(fin), .cnt_q(cnt_val)
  );

  lbist_prpg #(.W(W), .TAPS(TAPS), .SEED_DEF(PRPG_DEF)) u_prpg (
    .clk(clk), .rst_n(rst_n), .wr(wr_ok && reg_addr == ADDR_PRPG),
    .wdata(reg_wdata), .load_def(load_def), .step(run_step), .q(prpg_q)
  );

  lbist_core_stub #(.W(W), .MASK(RESP_MASK)) u_core (
    .clk(clk), .rst_n(rst_n), .flush(flush_rst), .iso(io_isolate),
    .func_in(func_in), .prpg(prpg_q), .func_out(func_out),
    .func_oe(func_oe), .resp(resp)
  );

  lbist_misr #(.W(W), .TAPS(TAPS), .SEED_DEF(SIG_DEF)) u_misr (
    .clk(clk), .rst_n(rst_n), .wr(wr_ok && reg_addr == ADDR_SIG),
    .wdata(reg_wdata), .load_def(load_def), .step(run_step),
    .resp(resp), .q(sig_q)
  );

  // Status word when idle: busy=0, done, last mode; even parity in the top bit.
  always_comb begin
    status_idle      = '0;
    status_idle[1]   = done_q;
    status_idle[2]   = user_mode;
    status_idle[W-1] = ^status_idle[W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (fin) done_q <= 1'b1;
      else if (reg_rd && reg_addr == ADDR_STATUS && !busy) done_q <= 1'b0;
      if (reg_rd) begin
        case (reg_addr)
          ADDR_STATUS: reg_rdata <= busy ? W'(1) : status_idle;
          ADDR_COUNT:  reg_rdata <= cnt_val;
          ADDR_PRPG:   reg_rdata <= prpg_q;
          default:     reg_rdata <= sig_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         io_isolate,
  input logic         flush_rst,
  input logic         func_oe,
  input logic         reg_rd,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_rdata,
  input logic [W-1:0] cnt_val,
  input logic         run_step
);
  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r2_flush_under_isolation: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rst |-> io_isolate);

  a_r2_flush_four_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_rst) |-> ($past(flush_rst, 1) && $past(flush_rst, 2) &&
                          $past(flush_rst, 3) && $past(flush_rst, 4)));

  a_r2_end_follows_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(flush_rst));

  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    run_step |=> (cnt_val == $past(cnt_val) - W'(1)));

  a_r9_status_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_rd && reg_addr == 2'd0) |=> (reg_rdata == W'(1)));

  a_r11_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !func_oe);
endmodule

bind lbist_ctrl lbist_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .io_isolate(io_isolate), .flush_rst(flush_rst), .func_oe(func_oe),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .cnt_val(cnt_val), .run_step(run_step)
);

// File: tb/sim_lbist_ctrl.sv
`timescale 1ns/1ps
module sim_lbist_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, start_user = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        busy, io_isolate, flush_rst, func_oe;
  logic [31:0] func_in = '0, func_out;

  int checks = 0, failures = 0;
  bit finished = 0;

  // measurement results of the last run
  int m_busy, m_flush_hi, m_flush_pulses, m_iso_bad, m_oe_bad;

  always #5 clk = ~clk;

  lbist_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_user(start_user),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .io_isolate(io_isolate), .flush_rst(flush_rst), .func_in(func_in),
    .func_out(func_out), .func_oe(func_oe)
  );

  function automatic logic [31:0] prpg_next(logic [31:0] p);
    return {p[30:0], p[31] ^ p[21] ^ p[1] ^ p[0]};
  endfunction
  function automatic logic [31:0] sig_next(logic [31:0] s, logic [31:0] p);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]} ^ ({p[15:0], p[31:16]} ^ 32'h5A5A_C3C3);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // Pulse start, then count cycles at falling edges until busy drops.
  task automatic run(bit user, bit meddle);
    bit prev_fl = 0;
    logic [31:0] st;
    @(negedge clk); start = 1'b1; start_user = user;
    @(negedge clk); start = 1'b0;
    m_busy = 0; m_flush_hi = 0; m_flush_pulses = 0; m_iso_bad = 0; m_oe_bad = 0;
    while (busy) begin
      m_busy++;
      if (flush_rst) m_flush_hi++;
      if (flush_rst && !prev_fl) m_flush_pulses++;
      prev_fl = flush_rst;
      if (!io_isolate) m_iso_bad++;
      if (func_oe) m_oe_bad++;
      if (meddle) begin
        if (m_busy == 12) begin
          reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd5; start = 1'b1; start_user = 1'b0;
        end else if (m_busy == 13) begin
          start = 1'b0; reg_addr = 2'd3; reg_wdata = 32'h1111_2222;
        end else if (m_busy == 14) begin
          reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 2'd0;
        end else if (m_busy == 15) begin
          reg_rd = 1'b0; st = reg_rdata;
          chk("R9 status while busy", st, 32'h0000_0001);
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_sig(logic [31:0] s0, logic [31:0] p0, int n,
                            output logic [31:0] s, output logic [31:0] p);
    s = s0; p = p0;
    for (int i = 0; i < n; i++) begin
      s = sig_next(s, p);
      p = prpg_next(p);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 busy at reset", 32'(busy), 0);
    chk("R11 oe at reset", 32'(func_oe), 1);
    chk("R2 flush at reset", 32'(flush_rst), 0);
    rd(2'd0, d);
    chk("R8 status at reset", d, 32'h0);
  endtask

  task automatic t_user_run();
    logic [31:0] d, es, ep;
    wr(2'd1, 32'd20); wr(2'd2, 32'h1234_5678); wr(2'd3, 32'h0);
    run(1'b1, 1'b0);
    chk("R2 busy cycles N=20", 32'(m_busy), 31);
    chk("R2 flush high cycles", 32'(m_flush_hi), 8);
    chk("R2 flush pulses", 32'(m_flush_pulses), 2);
    chk("R2 isolation during busy", 32'(m_iso_bad), 0);
    chk("R11 oe off during busy", 32'(m_oe_bad), 0);
    expect_sig(32'h0, 32'h1234_5678, 20, es, ep);
    rd(2'd3, d); chk("R6 R4 user signature", d, es);
    rd(2'd2, d); chk("R5 final pattern", d, ep);
    rd(2'd1, d); chk("R7 count ends at 0", d, 0);
    rd(2'd0, d); chk("R8 status done user", d, 32'h0000_0006);
    rd(2'd0, d); chk("R8 done cleared by read", d, 32'h8000_0004);
  endtask

  task automatic t_zero_count();
    logic [31:0] d;
    wr(2'd1, 32'd0); wr(2'd2, 32'h0BAD_F00D); wr(2'd3, 32'hCAFE_0001);
    run(1'b1, 1'b0);
    chk("R7 R2 busy cycles N=0", 32'(m_busy), 11);
    rd(2'd3, d); chk("R7 signature unchanged N=0", d, 32'hCAFE_0001);
    rd(2'd2, d); chk("R7 pattern unchanged N=0", d, 32'h0BAD_F00D);
  endtask

  task automatic t_busy_ignores();
    logic [31:0] d, es, ep;
    wr(2'd1, 32'd30); wr(2'd2, 32'h8765_4321); wr(2'd3, 32'h0F0F_0F0F);
    run(1'b1, 1'b1);
    chk("R10 R1 busy cycles unchanged by writes/start", 32'(m_busy), 41);
    expect_sig(32'h0F0F_0F0F, 32'h8765_4321, 30, es, ep);
    rd(2'd3, d); chk("R10 signature unaffected", d, es);
    rd(2'd0, d); chk("R1 mode kept as user", d, 32'h0000_0006);
  endtask

  task automatic t_isolation();
    wr(2'd1, 32'd3);
    @(negedge clk); func_in = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R11 idle pass-through", func_out, 32'hDEAD_BEEF);
    run(1'b1, 1'b0);
    chk("R11 core cleared after run", func_out, 32'h0);
    chk("R11 oe back on", 32'(func_oe), 1);
    @(negedge clk);
    chk("R11 pass-through resumes", func_out, 32'hDEAD_BEEF);
    func_in = '0;
  endtask

  task automatic t_default_run();
    logic [31:0] d, es, ep;
    wr(2'd1, 32'd7); wr(2'd2, 32'h5555_5555); wr(2'd3, 32'h1);
    run(1'b0, 1'b0);
    chk("R3 busy cycles default", 32'(m_busy), 83264 + 11);
    expect_sig(32'hFFFF_FFFF, 32'hACE1_2468, 83264, es, ep);
    rd(2'd3, d); chk("R3 default signature", d, es);
    rd(2'd2, d); chk("R3 R5 default final pattern", d, ep);
    rd(2'd0, d); chk("R8 status done default", d, 32'h8000_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_user_run();
    t_zero_count();
    t_busy_ignores();
    t_isolation();
    t_default_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule